// File: doc/BRIEF.md
# Vector ALU Output Modifier Unit

This stage sits between a SIMD ALU and register writeback. It receives a 128-bit result vector together with the element size, a float/integer flag, a 2-bit modifier code and a 2-bit narrowing mode. It rewrites the vector according to those controls and registers the result, so `valid_o` and `data_o` appear one clock after `valid_i`.

Float results can be clamped in three ways. Each clamp turns NaN into a fixed value. Clamping applies to 32-bit lanes and, when `HALF_FLOAT_EN` is set, to 16-bit lanes. Integer results can be narrowed to half the element width, either by saturating (signed or unsigned) or by keeping the low or high half of each element. The packed narrow results then go into one half of the destination, and the other half is zero.

Top module: `vec_outmod`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous cycle. `data_o` loads a new result only on a cycle with `valid_i` high and otherwise holds. Reset clears both to zero.
- R2: For a float vector (`is_float_i`=1), modifier code 0 returns each lane unchanged.
- R3: Float code 1 returns max(x, 0.0) per lane. NaN, any negative value and -0.0 give +0.0 (all bits zero).
- R4: Float code 2 clamps each lane to [-1.0, 1.0]. NaN gives -1.0 (32'hBF800000 for 32-bit lanes, 16'hBC00 for 16-bit lanes). ±inf saturates to ±1.0, and -0.0 is kept.
- R5: Float code 3 clamps each lane to [0.0, 1.0]. NaN and -0.0 give +0.0, and +inf gives 1.0.
- R6: Float lanes are chosen by `elem_size_i` (0=8, 1=16, 2=32, 3=64 bits). With size 0 or 3 the vector passes unchanged, and `shrink_i` has no effect on float vectors.
- R7: For an integer vector with `shrink_i` = 2 (no narrowing) or 3 (reserved), the vector passes unchanged whatever the modifier code.
- R8: Integer narrowing with `shrink_i` = 0 packs the 128/w half-width results into bits 63:0, with element i at bit i*w/2, and zeroes bits 127:64. `shrink_i` = 1 places the same packed results in bits 127:64 and zeroes bits 63:0. 8-bit elements are never narrowed and pass unchanged.
- R9: Integer code 0 saturates each signed w-bit element to the signed w/2-bit range.
- R10: Integer code 1 saturates each element, read as signed, to [0, 2^(w/2)-1]. Negative elements give 0.
- R11: Integer code 2 keeps the low w/2 bits of each element, and code 3 keeps the high w/2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector valid |
| data_i | input | 128 | ALU result vector |
| elem_size_i | input | 2 | Element size: 0=8, 1=16, 2=32, 3=64 bits |
| is_float_i | input | 1 | 1 = float lanes, 0 = integer elements |
| mod_i | input | 2 | Output modifier code |
| shrink_i | input | 2 | 0 = narrow to low half, 1 = narrow to high half, 2 = none, 3 = reserved |
| valid_o | output | 1 | Result valid |
| data_o | output | 128 | Modified result vector |

## Verification
The float clamps are driven with lanes that hold NaN, -0.0, +inf, in-range values and out-of-range values of both signs. This separates the NaN substitution of each mode from its ordinary clamp and catches sign handling at zero. Integer vectors carry elements just inside, at and beyond the half-width signed and unsigned limits at every element size. This separates the saturation bounds from the two truncation choices and checks where each packed element lands. Long runs of random controls and data, with idle cycles between them, then cover the reserved, pass-through and hold cases, all compared against a behavioural reference.

// File: rtl/vom_pkg.sv
package vom_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned HALF_W = VEC_W / 2;

  localparam logic [1:0] ES_8  = 2'd0;
  localparam logic [1:0] ES_16 = 2'd1;
  localparam logic [1:0] ES_32 = 2'd2;
  localparam logic [1:0] ES_64 = 2'd3;

  localparam logic [1:0] FM_NONE  = 2'd0;
  localparam logic [1:0] FM_POS   = 2'd1;
  localparam logic [1:0] FM_SNORM = 2'd2;
  localparam logic [1:0] FM_UNORM = 2'd3;

  localparam logic [1:0] IM_SSAT = 2'd0;
  localparam logic [1:0] IM_USAT = 2'd1;
  localparam logic [1:0] IM_LOW  = 2'd2;
  localparam logic [1:0] IM_HIGH = 2'd3;

  localparam logic [1:0] SHR_LO   = 2'd0;
  localparam logic [1:0] SHR_HI   = 2'd1;
  localparam logic [1:0] SHR_NONE = 2'd2;
endpackage

// File: rtl/vom_fclamp.sv
module vom_fclamp #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] x_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] y_o
);
  import vom_pkg::*;

  localparam logic [W-2:0] ONE_MAG = {1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic is_nan, sgn, ge_one;

  assign is_nan = (&x_i[W-2:MAN_W]) && (|x_i[MAN_W-1:0]);
  assign sgn    = x_i[W-1];
  assign ge_one = x_i[W-2:0] >= ONE_MAG;   // includes inf

  always_comb begin
    unique case (mode_i)
      FM_POS:   y_o = (is_nan || sgn) ? '0 : x_i;
      FM_SNORM: y_o = is_nan ? {1'b1, ONE_MAG} : (ge_one ? {sgn, ONE_MAG} : x_i);
      FM_UNORM: y_o = (is_nan || sgn) ? '0 : (ge_one ? {1'b0, ONE_MAG} : x_i);
      default:  y_o = x_i;
    endcase
  end
endmodule

// File: rtl/vom_fvec.sv
module vom_fvec #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned LANE_W = 1 + EXP_W + MAN_W,
  localparam int unsigned LANES  = VEC_W / LANE_W
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [1:0]       mode_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vom_fclamp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_clamp (
      .x_i   (vec_i[g*LANE_W +: LANE_W]),
      .mode_i(mode_i),
      .y_o   (vec_o[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vom_inarrow.sv
module vom_inarrow #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned H     = ELEM_W / 2,
  localparam int unsigned N     = VEC_W / ELEM_W
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [1:0]         mode_i,
  output logic [VEC_W/2-1:0] half_o
);
  import vom_pkg::*;

  localparam logic [H-1:0] S_MAX = {1'b0, {(H-1){1'b1}}};
  localparam logic [H-1:0] S_MIN = {1'b1, {(H-1){1'b0}}};

  for (genvar g = 0; g < N; g++) begin : g_elem
    logic [H-1:0] hi, lo, res;
    logic         neg, s_fits, u_fits;

    assign hi     = vec_i[g*ELEM_W + H +: H];
    assign lo     = vec_i[g*ELEM_W +: H];
    assign neg    = hi[H-1];
    assign s_fits = hi == {H{lo[H-1]}};
    assign u_fits = hi == '0;

    always_comb begin
      unique case (mode_i)
        IM_SSAT: res = s_fits ? lo : (neg ? S_MIN : S_MAX);
        IM_USAT: res = neg ? '0 : (u_fits ? lo : '1);
        IM_LOW:  res = lo;
        default: res = hi;
      endcase
    end

    assign half_o[g*H +: H] = res;
  end
endmodule

// File: rtl/vec_outmod.sv
module vec_outmod #(
  parameter bit HALF_FLOAT_EN = 1'b1,
  localparam int unsigned VEC_W  = vom_pkg::VEC_W,
  localparam int unsigned HALF_W = vom_pkg::HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic [1:0]       elem_size_i,
  input  logic             is_float_i,
  input  logic [1:0]       mod_i,
  input  logic [1:0]       shrink_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] data_o
);
  import vom_pkg::*;

  logic [VEC_W-1:0]  f32_res, f16_res, res;
  logic [HALF_W-1:0] narrow_res [1:3];
  logic [HALF_W-1:0] narrow_sel;

  vom_fvec #(.VEC_W(VEC_W), .EXP_W(8), .MAN_W(23)) i_f32 (
    .vec_i(data_i), .mode_i(mod_i), .vec_o(f32_res)
  );

  if (HALF_FLOAT_EN) begin : g_f16
    vom_fvec #(.VEC_W(VEC_W), .EXP_W(5), .MAN_W(10)) i_f16 (
      .vec_i(data_i), .mode_i(mod_i), .vec_o(f16_res)
    );
  end else begin : g_no_f16
    assign f16_res = data_i;
  end

  for (genvar k = 1; k <= 3; k++) begin : g_narrow
    vom_inarrow #(.VEC_W(VEC_W), .ELEM_W(8 << k)) i_narrow (
      .vec_i(data_i), .mode_i(mod_i), .half_o(narrow_res[k])
    );
  end

  always_comb begin
    unique case (elem_size_i)
      ES_16:   narrow_sel = narrow_res[1];
      ES_32:   narrow_sel = narrow_res[2];
      default: narrow_sel = narrow_res[3];
    endcase
  end

  always_comb begin
    res = data_i;
    if (is_float_i) begin
      if (elem_size_i == ES_32)      res = f32_res;
      else if (elem_size_i == ES_16) res = f16_res;
    end else if (elem_size_i != ES_8) begin
      if (shrink_i == SHR_LO)      res = {{HALF_W{1'b0}}, narrow_sel};
      else if (shrink_i == SHR_HI) res = {narrow_sel, {HALF_W{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res;
    end
  end

  // assertions
  localparam logic [31:0] F32_ONE  = 32'h3F80_0000;
  localparam logic [31:0] F32_MONE = 32'hBF80_0000;

  logic f32_sel;
  assign f32_sel = valid_i && is_float_i && (elem_size_i == ES_32);

  a_r1_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  a_r4_nan_neg_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f32_sel && mod_i == FM_SNORM && (&data_i[30:23]) && (|data_i[22:0])
    |=> data_o[31:0] == F32_MONE);

  for (genvar g = 0; g < VEC_W/32; g++) begin : g_chk
    a_r3_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      f32_sel && (mod_i == FM_POS || mod_i == FM_UNORM) |=> !data_o[32*g+31]);
    a_r5_le_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      f32_sel && mod_i == FM_UNORM |=> data_o[32*g +: 32] <= F32_ONE);
  end

  a_r7_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_float_i && shrink_i[1] |=> data_o == $past(data_i));

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_float_i && shrink_i == SHR_LO && elem_size_i != ES_8
    |=> data_o[VEC_W-1:HALF_W] == '0);

  a_r8_lower_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_float_i && shrink_i == SHR_HI && elem_size_i != ES_8
    |=> data_o[HALF_W-1:0] == '0);
endmodule

// File: tb/test_vec_outmod.sv
module test_vec_outmod;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [1:0]   elem_size_i = '0;
  logic         is_float_i = 1'b0;
  logic [1:0]   mod_i = '0;
  logic [1:0]   shrink_i = '0;
  logic         valid_o;
  logic [127:0] data_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  vec_outmod i_vec_outmod (.*);

  function automatic logic [31:0] f_ref(logic [31:0] x, int w, logic [1:0] md);
    int unsigned eb = (w == 32) ? 8 : 5;
    int unsigned mb = (w == 32) ? 23 : 10;
    int unsigned emask = (1 << eb) - 1;
    int unsigned ex = (x >> mb) & emask;
    int unsigned mn = x & ((1 << mb) - 1);
    int unsigned mag = x & ((1 << (w - 1)) - 1);
    int unsigned one = ((1 << (eb - 1)) - 1) << mb;
    int unsigned mone = one | (1 << (w - 1));
    bit nan = (ex == emask) && (mn != 0);
    bit neg = x[w-1];
    case (md)
      2'd0: return x;
      2'd1: return (nan || neg) ? 32'd0 : x;
      2'd2: if (nan) return mone;
            else if (mag >= one) return neg ? mone : one;
            else return x;
      default: if (nan || neg) return 32'd0;
               else if (mag >= one) return one;
               else return x;
    endcase
  endfunction

  function automatic logic [127:0] ref_out(logic [127:0] d, logic [1:0] es, bit fl,
                                           logic [1:0] md, logic [1:0] sh);
    logic [127:0] r = '0;
    int w = 8 << es;
    if (fl) begin
      if (w != 16 && w != 32) return d;
      for (int i = 0; i < 128 / w; i++) begin
        logic [31:0] x = 32'((d >> (i * w)) & ((128'd1 << w) - 1));
        r |= 128'(f_ref(x, w, md)) << (i * w);
      end
      return r;
    end
    if (sh[1] || w == 8) return d;
    for (int i = 0; i < 128 / w; i++) begin
      int h = w / 2;
      logic [63:0] e = 64'(d >> (i * w));
      logic signed [63:0] sv = $signed(e << (64 - w)) >>> (64 - w);
      longint smax = (longint'(1) <<< (h - 1)) - 1;
      longint smin = -(longint'(1) <<< (h - 1));
      longint umax = (longint'(1) <<< h) - 1;
      longint v;
      case (md)
        2'd0: v = (sv > smax) ? smax : (sv < smin) ? smin : sv;
        2'd1: v = (sv < 0) ? 0 : (sv > umax) ? umax : sv;
        2'd2: v = longint'(e);
        default: v = longint'(e >> h);
      endcase
      r |= 128'(64'(v) & 64'(umax)) << (i * h + (sh == 2'd1 ? 64 : 0));
    end
    return r;
  endfunction

  function automatic string tag_of(bit fl, logic [1:0] es, logic [1:0] md, logic [1:0] sh);
    if (fl) begin
      if (es == 2'd0 || es == 2'd3) return "R6";
      case (md) 2'd0: return "R2"; 2'd1: return "R3"; 2'd2: return "R4"; default: return "R5"; endcase
    end
    if (sh[1]) return "R7";
    if (es == 2'd0) return "R8";
    case (md) 2'd0: return "R9"; 2'd1: return "R10"; default: return "R11"; endcase
  endfunction

  task automatic apply(logic [127:0] d, logic [1:0] es, bit fl, logic [1:0] md, logic [1:0] sh);
    logic [127:0] exp_d = ref_out(d, es, fl, md, sh);
    string t = tag_of(fl, es, md, sh);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = d; elem_size_i = es; is_float_i = fl; mod_i = md; shrink_i = sh;
    @(negedge clk_i);
    valid_i = 1'b0;
    n_vec++;
    if (data_o !== exp_d || valid_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s es=%0d fl=%0d mod=%0d shr=%0d: got %h/%b exp %h/1",
               t, es, fl, md, sh, data_o, valid_o, exp_d);
    end
  endtask

  task automatic idle_check(logic [127:0] held);
    @(negedge clk_i);
    valid_i = 1'b0; data_i = ~held; mod_i = 2'd1; shrink_i = 2'd0;
    @(negedge clk_i);
    n_vec++;
    if (data_o !== held || valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 hold: got %h/%b exp %h/0", data_o, valid_o, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] fv32, fv16, iv16, iv32, iv64;
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (data_o !== '0 || valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %h/%b exp 0/0", data_o, valid_o);
    end
    rst_ni = 1'b1;

    // NaN, -0.0, 2.0, -3.0 ; then +inf, 0.5, -0.25, -inf
    fv32 = 128'h7FC00000_80000000_40000000_C0400000;
    for (int m = 0; m < 4; m++) apply(fv32, 2'd2, 1'b1, 2'(m), 2'd0);
    fv32 = 128'h7F800000_3F000000_BE800000_FF800000;
    for (int m = 0; m < 4; m++) apply(fv32, 2'd2, 1'b1, 2'(m), 2'd1);
    fv16 = 128'h7E01_8000_4000_C200_7C00_3800_B400_FC00;
    for (int m = 0; m < 4; m++) apply(fv16, 2'd1, 1'b1, 2'(m), 2'd0);
    apply(fv32, 2'd3, 1'b1, 2'd2, 2'd0);
    apply(fv32, 2'd0, 1'b1, 2'd3, 2'd1);

    iv16 = 128'h7FFF_8000_0080_FF7F_007F_FF80_00FF_0100;
    iv32 = 128'h00007FFF_FFFF8000_00010000_FFFFFFFF;
    iv64 = 128'h00000000_7FFFFFFF_FFFFFFFF_00000000;
    for (int m = 0; m < 4; m++) begin
      apply(iv16, 2'd1, 1'b0, 2'(m), 2'd0);
      apply(iv32, 2'd2, 1'b0, 2'(m), 2'd1);
      apply(iv64, 2'd3, 1'b0, 2'(m), 2'd0);
    end
    apply(iv32, 2'd2, 1'b0, 2'd2, 2'd2);
    apply(iv32, 2'd2, 1'b0, 2'd0, 2'd3);
    apply(iv16, 2'd0, 1'b0, 2'd0, 2'd0);
    idle_check(ref_out(iv16, 2'd0, 1'b0, 2'd0, 2'd0));

    for (int i = 0; i < 800; i++) begin
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      if (i % 4 == 1) d = d & {8{16'h807F}};
      apply(d, 2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
      if (i % 50 == 0) idle_check(ref_out(d, elem_size_i, is_float_i, mod_i, shrink_i));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule